// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block is the slave side of a three-wire synchronous serial memory of 4 kbit. A host raises chip select, toggles the serial clock and shifts in a start-framed instruction: a start bit, two opcode bits and an address. It can read one location, write one location, or erase one location to all ones. A read answers on the serial data output: a single zero comes first, then the word, most significant bit first. A write or erase is only armed by the serial transfer. The self-timed programming cycle begins when chip select is released. While that cycle runs, a host that selects the block again sees a busy/ready level on the data output.

All serial pins are brought into the system clock domain and the serial clock's rising edges are found there, so the whole block runs on one clock. The data output comes as a value plus an enable, which a pad or a bus-level tri-state buffer can turn into a high-impedance pin. The storage is a register array. One parameter picks the organization: 256 words of 16 bits, or 512 bytes.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the output enable is low, every location reads all ones, and the block is idle (not busy).
- R2: Data in is sampled on rising serial clock edges while chip select is high. Zeros before the first 1 (the start bit) are ignored. The start bit is followed by two opcode bits, then the address MSB first: 8 bits when WORD16=1, 9 bits when WORD16=0.
- R3: The output enable is low whenever chip select is low and while the start bit, opcode and address are being shifted.
- R4: Opcode 10 (first opcode bit 1, second 0) is a read. After the last address bit the output enable goes high and the output shows 0. Each following rising serial clock edge moves the output to the next bit of the addressed word, MSB first. The rising edge after the LSB turns the output enable off.
- R5: Opcode 01 is a write. It takes one full word of data bits MSB first after the address (16 bits when WORD16=1, 8 when WORD16=0). The location is programmed only after chip select is released, and a later read returns the data.
- R6: Opcode 11 is an erase. It takes no data and, after chip select is released, sets the addressed word to all ones.
- R7: The programming cycle lasts PROG_CYCLES system clocks from the release of chip select. A selection that starts during it drives the output enable high with the output at 0 while busy, and at 1 once the cycle is over, until chip select drops.
- R8: All serial input in a selection that started during a programming cycle is ignored, and memory contents are not changed by it.
- R9: A selection that follows a deselect time shorter than CS_MIN_CYCLES system clocks is ignored entirely. The output enable stays low and no instruction is executed.
- R10: WORD16=1 gives 256 words of 16 bits and WORD16=0 gives 512 words of 8 bits, both reachable through the full address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csIn | input | 1 | Chip select, high selects |
| sclkIn | input | 1 | Serial clock from the host |
| dinIn | input | 1 | Serial data in |
| doutOut | output | 1 | Serial data out value |
| doutEn | output | 1 | Data out drive enable; low means high impedance |

## Verification
The bench instantiates the block twice, once with WORD16=1 and once with WORD16=0, so the 8-bit and 9-bit address fields and the 16-bit and 8-bit data words are all exercised on random addresses. Both instances use PROG_CYCLES=300 and CS_MIN_CYCLES=12. These short values let a bench poll the busy level until it turns to ready, push a full ignored instruction into a programming cycle, and try a reselect that is too short, each within a few hundred clocks. The serial clock half period of eight system clocks leaves room for the synchronizer latency before each sample.

// File: rtl/smsl_pkg.sv
package smsl_pkg;

  typedef enum logic [3:0] {
    ST_DESEL, ST_IDLE, ST_OP, ST_ADDR, ST_DATA,
    ST_ARMED, ST_RLOAD, ST_READ, ST_HOLD
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic bitIn;
    logic shiftAddr;
    logic shiftData;
    logic loadOut;
    logic shiftOut;
    logic commit;
    logic eraseSel;
    logic driveOut;
    logic showStatus;
    logic ready;
  } dpStrobe_t;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;

endpackage

// File: rtl/serial_eeprom_ctrl.sv
module serial_eeprom_ctrl
  import smsl_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 16,
  parameter int PROG_CYCLES   = 2000,
  parameter int CS_MIN_CYCLES = 50
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      sclkIn,
  input  logic      dinIn,
  output dpStrobe_t stb
);

  localparam int MAXF   = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W  = $clog2(MAXF + 2);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);
  localparam int DSL_W  = $clog2(CS_MIN_CYCLES + 1);
  localparam logic [CNT_W-1:0]  ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0]  DATA_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0]  READ_END  = CNT_W'(DATA_W);
  localparam logic [BUSY_W-1:0] PROG_LEN  = BUSY_W'(PROG_CYCLES);
  localparam logic [DSL_W-1:0]  DSL_MIN   = DSL_W'(CS_MIN_CYCLES);

  logic [1:0] csSync, diSync;
  logic [2:0] skSync;
  logic selS, dinS, sclkRise;

  ctrlState_t state;
  logic [CNT_W-1:0]  bitCnt;
  logic [1:0]        opReg;
  logic              busy, pendErase, statusMode;
  logic [BUSY_W-1:0] busyCnt;
  logic [DSL_W-1:0]  deselCnt;
  logic              deselOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '0;
      diSync <= '0;
      skSync <= '0;
    end else begin
      csSync <= {csSync[0], csIn};
      diSync <= {diSync[0], dinIn};
      skSync <= {skSync[1:0], sclkIn};
    end
  end

  assign selS     = csSync[1];
  assign dinS     = diSync[1];
  assign sclkRise = skSync[1] & ~skSync[2];
  assign deselOk  = (deselCnt >= DSL_MIN);

  // programming timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      busyCnt   <= '0;
      pendErase <= 1'b0;
    end else if (busy) begin
      if (busyCnt == BUSY_W'(1)) busy <= 1'b0;
      busyCnt <= busyCnt - BUSY_W'(1);
    end else if (state == ST_ARMED && !selS) begin
      busy      <= 1'b1;
      busyCnt   <= PROG_LEN;
      pendErase <= (opReg == OP_ERASE);
    end
  end

  // deselect timer and status session
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deselCnt   <= DSL_MIN;
      statusMode <= 1'b0;
    end else if (!selS) begin
      statusMode <= 1'b0;
      if (!deselOk) deselCnt <= deselCnt + DSL_W'(1);
    end else if (state == ST_DESEL) begin
      deselCnt <= '0;
      if (deselOk && busy) statusMode <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DESEL;
      bitCnt <= '0;
      opReg  <= '0;
    end else if (!selS) begin
      state  <= ST_DESEL;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_DESEL: begin
          bitCnt <= '0;
          state  <= (!deselOk || busy) ? ST_HOLD : ST_IDLE;
        end
        ST_IDLE: if (sclkRise && dinS) begin
          state  <= ST_OP;
          bitCnt <= '0;
        end
        ST_OP: if (sclkRise) begin
          opReg <= {opReg[0], dinS};
          if (bitCnt == CNT_W'(1)) begin
            state  <= ST_ADDR;
            bitCnt <= '0;
          end else bitCnt <= bitCnt + CNT_W'(1);
        end
        ST_ADDR: if (sclkRise) begin
          bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == ADDR_LAST) begin
            bitCnt <= '0;
            case (opReg)
              OP_READ:  state <= ST_RLOAD;
              OP_WRITE: state <= ST_DATA;
              OP_ERASE: state <= ST_ARMED;
              default:  state <= ST_HOLD;
            endcase
          end
        end
        ST_DATA: if (sclkRise) begin
          bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == DATA_LAST) state <= ST_ARMED;
        end
        ST_RLOAD: begin
          state  <= ST_READ;
          bitCnt <= '0;
        end
        ST_READ: if (sclkRise) begin
          bitCnt <= bitCnt + CNT_W'(1);
          if (bitCnt == READ_END) state <= ST_HOLD;
        end
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.bitIn      = dinS;
    stb.shiftAddr  = (state == ST_ADDR) && sclkRise;
    stb.shiftData  = (state == ST_DATA) && sclkRise;
    stb.loadOut    = (state == ST_RLOAD);
    stb.shiftOut   = (state == ST_READ) && sclkRise;
    stb.commit     = busy && (busyCnt == BUSY_W'(1));
    stb.eraseSel   = pendErase;
    stb.driveOut   = selS && ((state == ST_READ) || statusMode);
    stb.showStatus = statusMode;
    stb.ready      = !busy;
  end

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(state inside {ST_OP, ST_ADDR, ST_DATA, ST_RLOAD, ST_READ, ST_ARMED}));

  // R5
  prog_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(state) == ST_ARMED) && !$past(selS));

  // R9
  short_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DESEL && selS && !deselOk) |=> (state == ST_HOLD) && !statusMode);

  // R7
  status_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selS |=> !statusMode);

endmodule

// File: rtl/serial_eeprom_dpath.sv
module serial_eeprom_dpath
  import smsl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t stb,
  output logic      doutOut,
  output logic      doutEn
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memQ [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic [DATA_W:0]   outReg;
  logic [DATA_W-1:0] rdWord, commitData;

  assign rdWord     = memQ[addrReg];
  assign commitData = stb.eraseSel ? {DATA_W{1'b1}} : dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      outReg  <= '0;
    end else begin
      if (stb.shiftAddr) addrReg <= {addrReg[ADDR_W-2:0], stb.bitIn};
      if (stb.shiftData) dataReg <= {dataReg[DATA_W-2:0], stb.bitIn};
      if (stb.loadOut)       outReg <= {1'b0, rdWord};
      else if (stb.shiftOut) outReg <= {outReg[DATA_W-1:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= {DATA_W{1'b1}};
    end else if (stb.commit) begin
      memQ[addrReg] <= commitData;
    end
  end

  assign doutEn  = stb.driveOut;
  assign doutOut = stb.driveOut && (stb.showStatus ? stb.ready : outReg[DATA_W]);

  // R4
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |=> !outReg[DATA_W] && (outReg[DATA_W-1:0] == $past(rdWord)));

  // R5
  commit_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> memQ[$past(addrReg)] == $past(commitData));

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import smsl_pkg::*;
#(
  parameter bit WORD16        = 1'b1,
  parameter int PROG_CYCLES   = 2000,
  parameter int CS_MIN_CYCLES = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic sclkIn,
  input  logic dinIn,
  output logic doutOut,
  output logic doutEn
);

  // R10
  localparam int DATA_W = WORD16 ? 16 : 8;
  localparam int ADDR_W = WORD16 ? 8 : 9;

  dpStrobe_t stb;

  serial_eeprom_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYCLES(PROG_CYCLES), .CS_MIN_CYCLES(CS_MIN_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .dinIn(dinIn), .stb(stb)
  );

  serial_eeprom_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .doutOut(doutOut), .doutEn(doutEn)
  );

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!csIn, 3) && !csIn |-> !doutEn);

endmodule

// File: tb/serial_eeprom_slave_tb.sv
`timescale 1ns/1ps
module serial_eeprom_slave_tb;

  localparam int PROG = 300;
  localparam int CSM  = 12;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs16 = 1'b0, cs8 = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout16, en16, dout8, en8;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [15:0] obsWord;
  event        wordSeen;

  always #2.5 clk = ~clk;

  serial_eeprom_slave #(.WORD16(1'b1), .PROG_CYCLES(PROG), .CS_MIN_CYCLES(CSM)) u_dut (
    .clk(clk), .rstN(rstN), .csIn(cs16), .sclkIn(sclk), .dinIn(din),
    .doutOut(dout16), .doutEn(en16));

  serial_eeprom_slave #(.WORD16(1'b0), .PROG_CYCLES(PROG), .CS_MIN_CYCLES(CSM)) u_dut8 (
    .clk(clk), .rstN(rstN), .csIn(cs8), .sclkIn(sclk), .dinIn(din),
    .doutOut(dout8), .doutEn(en8));

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic curEn(bit org);
    return org ? en16 : en8;
  endfunction

  function automatic logic curDout(bit org);
    return org ? dout16 : dout8;
  endfunction

  task automatic setCs(bit org, logic v);
    if (org) cs16 = v; else cs8 = v;
  endtask

  task automatic select(bit org);
    setCs(org, 1'b1);
    waitClk(4);
  endtask

  task automatic deselect(bit org);
    sclk = 1'b0;
    setCs(org, 1'b0);
    waitClk(CSM + 6);
  endtask

  task automatic clkBit(logic b);
    din = b;
    sclk = 1'b0;
    waitClk(HALF);
    sclk = 1'b1;
    waitClk(HALF);
  endtask

  // R2 framing: leading zeros, start bit, opcode, address MSB first
  task automatic sendCmd(bit org, logic [1:0] op, logic [8:0] addr, int lead, output bit enSeen);
    int aw = org ? 8 : 9;
    enSeen = 0;
    for (int i = 0; i < lead; i++) begin clkBit(1'b0); enSeen |= curEn(org); end
    clkBit(1'b1); enSeen |= curEn(org);
    clkBit(op[1]); enSeen |= curEn(org);
    clkBit(op[0]); enSeen |= curEn(org);
    for (int i = aw - 1; i >= 0; i--) begin
      clkBit(addr[i]);
      if (i > 0) enSeen |= curEn(org);
    end
  endtask

  task automatic readWord(bit org, logic [8:0] addr, int lead, logic [15:0] exp, string tag);
    int dw = org ? 16 : 8;
    bit enSeen;
    logic [15:0] obs = '0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    select(org);
    sendCmd(org, 2'b10, addr, lead, enSeen);
    chk(!enSeen, "R3 enable low during command shift", int'(enSeen), 0);
    sclk = 1'b0;
    waitClk(HALF);
    chk(curEn(org) && curDout(org) == 1'b0, "R4 leading dummy zero driven",
        {curEn(org), curDout(org)}, 2);
    for (int i = 0; i < dw; i++) begin
      sclk = 1'b1; waitClk(HALF);
      sclk = 1'b0; waitClk(HALF);
      obs = {obs[14:0], curDout(org)};
    end
    sclk = 1'b1; waitClk(HALF);
    chk(!curEn(org), "R4 enable off after LSB", int'(curEn(org)), 0);
    obsWord = obs;
    ->wordSeen;
    deselect(org);
  endtask

  task automatic writeWord(bit org, logic [8:0] addr, logic [15:0] data, bit erase);
    int dw = org ? 16 : 8;
    bit enSeen;
    select(org);
    sendCmd(org, erase ? 2'b11 : 2'b01, addr, 2, enSeen);
    if (!erase) for (int i = dw - 1; i >= 0; i--) clkBit(data[i]);
    sclk = 1'b0;
    waitClk(2);
    deselect(org);
  endtask

  task automatic pollReady(bit org, string tag);
    int n = 0;
    select(org);
    waitClk(2);
    chk(curEn(org) && curDout(org) == 1'b0, {"R7 busy level low ", tag},
        {curEn(org), curDout(org)}, 2);
    while (curDout(org) == 1'b0 && n < PROG + 60) begin waitClk(1); n++; end
    chk(curEn(org) && curDout(org) == 1'b1, {"R7 ready level high ", tag},
        {curEn(org), curDout(org)}, 3);
    chk(n >= PROG - 50 && n <= PROG, {"R7 cycle length ", tag}, n, PROG - 25);
    deselect(org);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      logic [15:0] e;
      string t;
      @(wordSeen);
      if (expQ.size() == 0) chk(0, "scoreboard empty", 0, 1);
      else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(obsWord == e, t, obsWord, e);
      end
    end
  end

  task automatic runOrg(bit org);
    logic [15:0] mask = org ? 16'hFFFF : 16'h00FF;
    logic [8:0]  amask = org ? 9'h0FF : 9'h1FF;
    logic [8:0]  a1 = 9'($urandom) & amask;
    logic [8:0]  a2 = a1 ^ 9'h001;
    logic [8:0]  aTop = amask;
    logic [15:0] d1 = 16'($urandom) & mask;
    logic [15:0] d2 = (16'($urandom) & mask) ^ 16'h0001;
    bit enSeen;
    bit enAny;

    readWord(org, a1, 0, mask, org ? "R1 erased after reset" : "R10 R1 x8 erased after reset");
    // R5 write then read, with leading zeros (R2)
    writeWord(org, a1, d1, 0);
    pollReady(org, "after write");
    readWord(org, a1, 3, d1, org ? "R5 write readback" : "R10 R5 x8 write readback");
    // top of address range
    writeWord(org, aTop, d2 ^ mask, 0);
    pollReady(org, "top write");
    readWord(org, aTop, 1, (d2 ^ mask) & mask, "R10 top address readback");
    // R8 instruction during busy ignored
    writeWord(org, a2, d2, 0);
    writeWord(org, a1, ~d1 & mask, 0);
    waitClk(PROG + 20);
    readWord(org, a1, 0, d1, "R8 write during busy ignored");
    readWord(org, a2, 2, d2, "R5 second write readback");
    // R6 erase
    writeWord(org, a1, '0, 1);
    pollReady(org, "after erase");
    readWord(org, a1, 0, mask, "R6 erase gives all ones");
    // R9 short reselect ignored
    select(org);
    setCs(org, 1'b0);
    waitClk(2);
    select(org);
    sendCmd(org, 2'b11, a2, 1, enSeen);
    enAny = enSeen;
    for (int i = 0; i < 18; i++) begin clkBit(1'b0); enAny |= curEn(org); end
    chk(!enAny, "R9 short reselect output stays off", int'(enAny), 0);
    deselect(org);
    waitClk(PROG + 20);
    readWord(org, a2, 0, d2, "R9 short reselect erase not executed");
  endtask

  initial begin
    waitClk(3);
    chk(!en16 && !en8, "R1 enable low in reset", {en16, en8}, 0);
    rstN = 1'b1;
    waitClk(4);
    chk(!en16 && !en8, "R3 enable low while deselected", {en16, en8}, 0);
    runOrg(1'b1);
    runOrg(1'b0);
    waitClk(4);
    chk(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule